// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Check Cycle

This block is a small multicycle processor built around one 16-bit accumulator. Code and data share one word-addressed memory. Each instruction word holds a 4-bit operation code in its top bits and a 12-bit direct word address below it. Every instruction passes through three phases. A fetch phase reads the word at the program counter into the instruction register. An execute phase carries out the operation. An interrupt check phase then either goes on to the next fetch or diverts to a fixed handler address.

The core never drives memory directly from the program counter or the accumulator. A memory address register feeds the memory address port, and a memory buffer register receives read data and holds the data to be written. The memory is a synchronous single-port RAM with one cycle of read latency.

There is one interrupt request input, sampled on each clock edge. When the core takes an interrupt, it saves the return address in an internal register, masks further interrupts and jumps to the handler. A request that arrives while interrupts are masked is remembered and served once software unmasks them. A debug view shows the program counter, the instruction register and the accumulator. A halt output signals that execution has stopped.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted and after it is released, the core shows PC = RESET_PC (default 0x300), AC = 0, IR = 0, halt low and no memory write. Interrupts start masked with no request pending.
- R2: Bits [15:12] of an instruction are the operation code and bits [11:0] are a word address. The PC advances by exactly 1 in the cycle after each instruction word is read.
- R3: Opcode 0x1 copies the addressed memory word into AC.
- R4: Opcode 0x5 adds the addressed memory word to AC, modulo 2^16, and keeps the result in AC.
- R5: Opcode 0x2 writes AC to the addressed word. The write enable is high for exactly one cycle per store.
- R6: Each instruction takes a fixed number of cycles from one instruction-register load to the next: 7 for load and add, 6 for store, and 5 for any other opcode that continues.
- R7: Any opcode other than 0x1, 0x2, 0x5, 0xA, 0xB and 0xF leaves AC and memory unchanged, and execution moves on to the next address.
- R8: In the check phase after an execute, if interrupts are enabled and a request is present or pending, the core saves PC in EPC, loads PC with HANDLER_ADDR (default 0xF00) and masks interrupts.
- R9: A request that is high for even a single cycle while interrupts are masked stays pending. It is taken at the first check phase after interrupts are enabled, for example by opcode 0xB.
- R10: Opcode 0xA loads PC from EPC and re-enables interrupts, so execution resumes at the instruction after the interrupted one.
- R11: Opcode 0xF raises halt one cycle after it enters IR. From then until reset, halt stays high, PC does not change and no memory write occurs.
- R12: If software never enables interrupts, a request held high for a whole program never diverts execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq | input | 1 | Interrupt request, sampled every clock |
| mem_addr | output | 12 | Memory word address, driven from the address register |
| mem_wdata | output | 16 | Memory write data, driven from the buffer register |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address is sampled |
| halt | output | 1 | High once a halt instruction has executed |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_ac | output | 16 | Accumulator |

## Verification
The bench builds the core with the default parameters: a 16-bit word, a start address of 0x300 and a handler at 0xF00. With these values the classic three-instruction example (load 0x940, add 0x941, store 0x941) runs unchanged, and the handler sits far enough from the main program that any stray diversion shows up in the final PC and in memory. The handler increments a counter word in memory. A short single-cycle pulse on irq, given before interrupts are enabled or while the handler runs, therefore shows in that count and in the return address whether the request was kept pending or was taken too early.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_FWAIT  = 4'd1,
    ST_DECODE = 4'd2,
    ST_EXEC   = 4'd3,
    ST_OPWAIT = 4'd4,
    ST_OPDONE = 4'd5,
    ST_STORE  = 4'd6,
    ST_INTCHK = 4'd7,
    ST_HALT   = 4'd8
  } cpu_state_t;

  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h5;
  localparam logic [3:0] OP_RETI  = 4'hA;
  localparam logic [3:0] OP_EI    = 4'hB;
  localparam logic [3:0] OP_HALT  = 4'hF;

  // Datapath strobes issued by the sequencer, one bundle per cycle
  typedef struct packed {
    logic pc_inc;
    logic pc_epc;
    logic mar_ir;
    logic mbr_mem;
    logic mbr_ac;
    logic ir_ld;
    logic ac_ld;
    logic ac_add;
    logic mem_we;
    logic set_ie;
    logic int_upd;
  } cpu_ctl_t;

endpackage

// File: rtl/acc_cpu_rstsync.sv
module acc_cpu_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode,
  output cpu_state_t state,
  output cpu_ctl_t   ctl,
  output logic       halted
);

  cpu_state_t state_q;
  cpu_state_t state_nxt;

  always_comb begin
    state_nxt = state_q;
    ctl       = '0;
    unique case (state_q)
      ST_FETCH: begin
        ctl.pc_inc = 1'b1;
        state_nxt  = ST_FWAIT;
      end
      ST_FWAIT: begin
        ctl.mbr_mem = 1'b1;
        state_nxt   = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.ir_ld  = 1'b1;
        ctl.mar_ir = 1'b1;
        state_nxt  = ST_EXEC;
      end
      ST_EXEC: begin
        case (opcode)
          OP_LOAD, OP_ADD: state_nxt = ST_OPWAIT;
          OP_STORE: begin
            ctl.mbr_ac = 1'b1;
            state_nxt  = ST_STORE;
          end
          OP_RETI: begin
            ctl.pc_epc = 1'b1;
            ctl.set_ie = 1'b1;
            state_nxt  = ST_INTCHK;
          end
          OP_EI: begin
            ctl.set_ie = 1'b1;
            state_nxt  = ST_INTCHK;
          end
          OP_HALT: state_nxt = ST_HALT;
          default: state_nxt = ST_INTCHK;
        endcase
      end
      ST_OPWAIT: begin
        ctl.mbr_mem = 1'b1;
        state_nxt   = ST_OPDONE;
      end
      ST_OPDONE: begin
        ctl.ac_ld  = 1'b1;
        ctl.ac_add = (opcode == OP_ADD);
        state_nxt  = ST_INTCHK;
      end
      ST_STORE: begin
        ctl.mem_we = 1'b1;
        state_nxt  = ST_INTCHK;
      end
      ST_INTCHK: begin
        ctl.int_upd = 1'b1;
        state_nxt   = ST_FETCH;
      end
      ST_HALT: state_nxt = ST_HALT;
      default: state_nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_nxt;
    end
  end

  assign state  = state_q;
  assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/acc_cpu_irq.sv
module acc_cpu_irq #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic              int_chk,
  input  logic              set_ie,
  input  logic [ADDR_W-1:0] pc,
  output logic              take,
  output logic              irq_en,
  output logic [ADDR_W-1:0] epc
);

  logic              ie_q, ie_nxt;
  logic              pend_q, pend_nxt;
  logic [ADDR_W-1:0] epc_q;
  logic              epc_en;

  assign take   = int_chk & ie_q & (pend_q | irq);
  assign epc_en = take;

  always_comb begin
    pend_nxt = pend_q | irq;
    if (take) pend_nxt = 1'b0;
    ie_nxt = ie_q;
    if (set_ie) ie_nxt = 1'b1;
    if (take)   ie_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      epc_q  <= '0;
    end else begin
      ie_q   <= ie_nxt;
      pend_q <= pend_nxt;
      if (epc_en) epc_q <= pc;
    end
  end

  assign irq_en = ie_q;
  assign epc    = epc_q;

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 12,
  parameter int RESET_PC     = 'h300,
  parameter int HANDLER_ADDR = 'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cpu_ctl_t          ctl,
  input  logic              take,
  input  logic [ADDR_W-1:0] epc,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] ac
);

  localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(RESET_PC);
  localparam logic [ADDR_W-1:0] VEC_ADDR   = ADDR_W'(HANDLER_ADDR);

  logic [ADDR_W-1:0] pc_q, pc_nxt, mar_q, mar_nxt;
  logic [DATA_W-1:0] mbr_q, mbr_nxt, ir_q, ac_q, ac_nxt;
  logic              pc_en, mar_en, mbr_en, ir_en, ac_en;
  logic              vec;

  assign vec = ctl.int_upd & take;

  always_comb begin
    pc_en  = ctl.pc_inc | ctl.pc_epc | vec;
    pc_nxt = pc_q + 1'b1;
    if (ctl.pc_epc) pc_nxt = epc;
    if (vec)        pc_nxt = VEC_ADDR;

    mar_en  = ctl.mar_ir | ctl.int_upd;
    mar_nxt = pc_q;
    if (ctl.mar_ir) mar_nxt = mbr_q[ADDR_W-1:0];
    if (vec)        mar_nxt = VEC_ADDR;

    mbr_en  = ctl.mbr_mem | ctl.mbr_ac;
    mbr_nxt = ctl.mbr_ac ? ac_q : mem_rdata;

    ir_en = ctl.ir_ld;

    ac_en  = ctl.ac_ld;
    ac_nxt = ctl.ac_add ? (ac_q + mbr_q) : mbr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= START_ADDR;
      mar_q <= START_ADDR;
      mbr_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_nxt;
      if (mar_en) mar_q <= mar_nxt;
      if (mbr_en) mbr_q <= mbr_nxt;
      if (ir_en)  ir_q  <= mbr_q;
      if (ac_en)  ac_q  <= ac_nxt;
    end
  end

  assign pc  = pc_q;
  assign mar = mar_q;
  assign mbr = mbr_q;
  assign ir  = ir_q;
  assign ac  = ac_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int RESET_PC     = 'h300,
  parameter int HANDLER_ADDR = 'hF00,
  localparam int OPC_W       = 4,
  localparam int ADDR_W      = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halt,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_ir,
  output logic [DATA_W-1:0] dbg_ac
);

  logic              rst_s_n;
  cpu_state_t        state;
  cpu_ctl_t          ctl;
  logic              take;
  logic              irq_en;
  logic [ADDR_W-1:0] epc;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q, ac_q;
  logic [OPC_W-1:0]  opcode;

  assign opcode = ir_q[DATA_W-1 -: OPC_W];

  acc_cpu_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  acc_cpu_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .opcode (opcode),
    .state  (state),
    .ctl    (ctl),
    .halted (halt)
  );

  acc_cpu_irq #(.ADDR_W(ADDR_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .irq     (irq),
    .int_chk (ctl.int_upd),
    .set_ie  (ctl.set_ie),
    .pc      (pc_q),
    .take    (take),
    .irq_en  (irq_en),
    .epc     (epc)
  );

  acc_cpu_dpath #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .RESET_PC     (RESET_PC),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .ctl       (ctl),
    .take      (take),
    .epc       (epc),
    .mem_rdata (mem_rdata),
    .pc        (pc_q),
    .mar       (mar_q),
    .mbr       (mbr_q),
    .ir        (ir_q),
    .ac        (ac_q)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_we    = ctl.mem_we;
  assign dbg_pc    = pc_q;
  assign dbg_ir    = ir_q;
  assign dbg_ac    = ac_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 12,
  parameter int HANDLER_ADDR = 'hF00
) (
  input logic              clk,
  input logic              rst_n,
  input cpu_state_t        state,
  input logic              mem_we,
  input logic              halt,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ac,
  input logic              take,
  input logic              ie
);

  // R5
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && $stable(pc) && !mem_we));

  // R8
  vector_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((pc == ADDR_W'(HANDLER_ADDR)) && !ie));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R3
  ac_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ac) |-> ($past(state) == ST_OPDONE));

endmodule

bind acc_cpu acc_cpu_chk #(
  .DATA_W       (DATA_W),
  .ADDR_W       (ADDR_W),
  .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_s_n),
  .state  (state),
  .mem_we (mem_we),
  .halt   (halt),
  .pc     (pc_q),
  .ac     (ac_q),
  .take   (take),
  .ie     (irq_en)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

  logic        clk;
  logic        rst_n;
  logic        irq;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic        halt;
  logic [11:0] dbg_pc;
  logic [15:0] dbg_ir;
  logic [15:0] dbg_ac;

  logic [15:0] mem [0:4095];

  int n_cmp = 0;
  int n_bad = 0;

  acc_cpu dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .halt      (halt),
    .dbg_pc    (dbg_pc),
    .dbg_ir    (dbg_ir),
    .dbg_ac    (dbg_ac)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // synchronous memory, one cycle of read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] v);
    mem[a] <= v;
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    irq   = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] <= 16'h0000;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_handler();
    poke('hF00, 16'h1960);
    poke('hF01, 16'h5961);
    poke('hF02, 16'h2960);
    poke('hF03, 16'hA000);
    poke('h961, 16'h0001);
  endtask

  task automatic run_to_halt(input string req, input int limit);
    int n = 0;
    while (!halt && n < limit) begin
      @(negedge clk);
      n++;
    end
    check({req, " halt reached"}, 32'(halt), 32'd1);
  endtask

  task automatic t_reset();
    hold_reset();
    check("R1 pc in reset", 32'(dbg_pc), 32'h300);
    check("R1 ac in reset", 32'(dbg_ac), 32'h0);
    check("R1 ir in reset", 32'(dbg_ir), 32'h0);
    check("R1 halt in reset", 32'(halt), 32'h0);
    check("R1 we in reset", 32'(mem_we), 32'h0);
    release_reset();
    @(negedge clk);
    check("R1 pc after release", 32'(dbg_pc), 32'h300);
  endtask

  task automatic t_add_example();
    hold_reset();
    poke('h300, 16'h1940);
    poke('h301, 16'h5941);
    poke('h302, 16'h2941);
    poke('h303, 16'hF000);
    poke('h940, 16'h0003);
    poke('h941, 16'h0002);
    release_reset();
    run_to_halt("R3", 200);
    check("R4 sum stored", 32'(mem['h941]), 32'h5);
    check("R3 ac after add", 32'(dbg_ac), 32'h5);
    check("R2 pc after halt fetch", 32'(dbg_pc), 32'h304);
    check("R11 ir holds halt", 32'(dbg_ir), 32'hF000);
  endtask

  task automatic t_halt_hold();
    logic [11:0] pc0;
    int          wr;
    pc0 = dbg_pc;
    wr  = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mem_we) wr++;
    end
    check("R11 halt stays", 32'(halt), 32'h1);
    check("R11 pc frozen", 32'(dbg_pc), 32'(pc0));
    check("R11 no writes", 32'(wr), 32'h0);
  endtask

  task automatic t_add_wrap();
    hold_reset();
    poke('h300, 16'h1940);
    poke('h301, 16'h5941);
    poke('h302, 16'h2942);
    poke('h303, 16'hF000);
    poke('h940, 16'hFFFF);
    poke('h941, 16'h0003);
    release_reset();
    run_to_halt("R4", 200);
    check("R4 wrapped sum", 32'(mem['h942]), 32'h0002);
  endtask

  task automatic t_store_pulse();
    int we_cycles;
    hold_reset();
    poke('h300, 16'h1940);
    poke('h301, 16'h2950);
    poke('h302, 16'h2951);
    poke('h303, 16'hF000);
    poke('h940, 16'h5A5A);
    release_reset();
    we_cycles = 0;
    for (int i = 0; i < 200 && !halt; i++) begin
      @(negedge clk);
      if (mem_we) we_cycles++;
    end
    check("R5 write cycles", 32'(we_cycles), 32'd2);
    check("R5 first store", 32'(mem['h950]), 32'h5A5A);
    check("R5 second store", 32'(mem['h951]), 32'h5A5A);
  endtask

  task automatic t_timing();
    int          t [0:4];
    int          k;
    int          cyc;
    int          t_halt;
    logic [15:0] prev;
    hold_reset();
    poke('h300, 16'h1940);
    poke('h301, 16'h7000);
    poke('h302, 16'h2950);
    poke('h303, 16'h8000);
    poke('h304, 16'hF000);
    release_reset();
    k = 0;
    cyc = 0;
    t_halt = -1;
    prev = dbg_ir;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      cyc++;
      if (dbg_ir !== prev && k < 5) begin
        t[k] = cyc;
        k++;
      end
      prev = dbg_ir;
      if (halt && t_halt < 0) t_halt = cyc;
    end
    check("R6 ir loads seen", 32'(k), 32'd5);
    if (k == 5) begin
      check("R6 load cycles", 32'(t[1] - t[0]), 32'd7);
      check("R6 other cycles", 32'(t[2] - t[1]), 32'd5);
      check("R6 store cycles", 32'(t[3] - t[2]), 32'd6);
      check("R6 other cycles 2", 32'(t[4] - t[3]), 32'd5);
      check("R11 halt latency", 32'(t_halt - t[4]), 32'd1);
    end
  endtask

  task automatic t_noop();
    hold_reset();
    poke('h300, 16'h1940);
    poke('h301, 16'h7123);
    poke('h302, 16'hC000);
    poke('h303, 16'h2950);
    poke('h304, 16'hF000);
    poke('h940, 16'hABCD);
    release_reset();
    run_to_halt("R7", 200);
    check("R7 ac kept", 32'(dbg_ac), 32'hABCD);
    check("R7 store after no-op", 32'(mem['h950]), 32'hABCD);
    check("R7 target word untouched", 32'(mem['h123]), 32'h0);
    check("R7 pc advanced", 32'(dbg_pc), 32'h305);
  endtask

  task automatic t_masked();
    hold_reset();
    load_handler();
    poke('h300, 16'h1940);
    poke('h301, 16'h2950);
    poke('h302, 16'hF000);
    poke('h940, 16'h1234);
    irq = 1'b1;
    release_reset();
    run_to_halt("R12", 200);
    irq = 1'b0;
    check("R12 no handler run", 32'(mem['h960]), 32'h0);
    check("R12 pc main path", 32'(dbg_pc), 32'h303);
  endtask

  task automatic pending_prog();
    hold_reset();
    load_handler();
    poke('h300, 16'h7000);
    poke('h301, 16'h7000);
    poke('h302, 16'hB000);
    poke('h303, 16'h1940);
    poke('h304, 16'h2950);
    poke('h305, 16'hF000);
    poke('h940, 16'h0BEE);
    release_reset();
    repeat (4) @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
  endtask

  task automatic t_pending();
    logic saw_vec;
    pending_prog();
    saw_vec = 1'b0;
    for (int i = 0; i < 300 && !halt; i++) begin
      @(negedge clk);
      if (dbg_pc == 12'hF00) saw_vec = 1'b1;
    end
    check("R8 handler entered", 32'(saw_vec), 32'h1);
    check("R9 pending served once", 32'(mem['h960]), 32'h1);
    check("R10 resumed main", 32'(mem['h950]), 32'h0BEE);
    check("R10 final pc", 32'(dbg_pc), 32'h306);
  endtask

  task automatic t_mask_in_handler();
    logic pulsed;
    pending_prog();
    pulsed = 1'b0;
    for (int i = 0; i < 400 && !halt; i++) begin
      @(negedge clk);
      if (!pulsed && dbg_pc == 12'hF02) begin
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        pulsed = 1'b1;
      end
    end
    check("R8 masked in handler, retaken after return", 32'(mem['h960]), 32'h2);
    check("R10 main completes", 32'(mem['h950]), 32'h0BEE);
    check("R10 final pc 2", 32'(dbg_pc), 32'h306);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq   = 1'b0;
    t_reset();
    t_add_example();
    t_halt_hold();
    t_add_wrap();
    t_store_pulse();
    t_timing();
    t_noop();
    t_masked();
    t_pending();
    t_mask_in_handler();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule